// File: doc/BRIEF.md
# Pin Edge Interrupt and Sleep Wake Unit

This block watches a small group of general-purpose input pins and turns activity on them into an interrupt request. In run mode every pin is brought into the port clock domain by a synchronizer, and a selected transition (rising or falling, chosen per pin) sets a sticky cause flag. Software reads the flags, clears them by writing ones, and masks each pin's contribution to the interrupt line with an enable bit.

When software strobes sleep entry, the port clock is expected to stop. Edge capture cannot work without a clock, so each enabled pin switches to a level test that matches its polarity. A rising pin requests wake while high and a falling pin requests wake while low. The wake output is formed without any clocked element and reaches the clock controller with the clock stopped. As a result, a pin that already sits at its active level when sleep is entered produces a wake at once. The first port clock edge seen while wake is high takes the block out of sleep, and wake then drops.

Top module: `pin_irq_wake`

## Requirements
- R1: Register access uses a 2-bit address. Address 0 holds the polarity vector (bit = 1 rising, 0 falling). Address 1 holds the enable vector, and both read back what was written. Address 2 reads the flag vector and address 3 reads zero. The read data follows the read address without a clock.
- R2: In run mode, with the default two synchronizer stages, a rising-polarity pin that goes high between two clock edges has its flag set after the third rising port clock edge, and not after the second.
- R3: A falling-polarity pin sets its flag on a high-to-low input change, with the same latency as R2.
- R4: Writing to address 2 clears each flag whose data bit is 1. Flags whose data bit is 0 are left alone, and a set flag otherwise holds until cleared.
- R5: If an edge on a pin reaches its flag in the same cycle that a clear of that flag is written, the flag ends set.
- R6: `irq_o` is high exactly when some pin has both its flag and its enable bit at 1. A flag set on a disabled pin is still readable but does not raise `irq_o`.
- R7: In sleep, `wake_o` is high while any enabled pin is at its active level (high for rising, low for falling), with no clock edge needed. Disabled pins never cause wake, and `wake_o` is low outside sleep.
- R8: A `sleep_enter` pulse puts the block in sleep at the next clock edge. If an enabled pin is already at its active level, `wake_o` is high right after that edge.
- R9: An enabled falling pin that is high at sleep entry keeps `wake_o` low until the pin goes low.
- R10: The block leaves sleep at the first clock edge where `wake_o` is high and `sleep_enter` is low, and `wake_o` is then low. `sleep_enter` takes priority over leaving.
- R11: No flag becomes set while the block is in sleep, even if the clock keeps running and a pin toggles.
- R12: In run mode, an input pulse wider than one port clock period is always captured in its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, may be stopped during sleep |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Raw input pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | NUM_PINS | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | NUM_PINS | Register read data |
| sleep_enter | input | 1 | Sleep entry strobe |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Combinational wake request |

## Verification
Assertions check on every clock that a held flag stays held until a clear, that an edge into a flag sets it regardless of a clear, and that flags stay frozen through sleep. They also check that wake only appears in sleep, that entry and exit of sleep follow the strobe and the wake, and that polarity writes land. The combinational wake with the clock stopped, the exact three-edge capture latency, pulse capture and the masking of irq by enable can only be shown by the bench's scenarios. The bench compares these against its reference model on each cycle and also samples wake between clock edges with the clock gated off.

// File: rtl/piw_pkg.sv
package piw_pkg;
   localparam int unsigned REG_ADDR_W = 2;
   typedef enum logic [REG_ADDR_W-1:0] {
      REG_POL  = 2'd0,
      REG_EN   = 2'd1,
      REG_FLAG = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/piw_sync.sv
module piw_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("piw_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= 1'b0;
      else        chain_q[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= 1'b0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/piw_pin_cell.sv
module piw_pin_cell #(
   parameter bit FLAG_INIT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_raw_i,
   input  logic pin_sync_i,
   input  logic pol_i,
   input  logic en_i,
   input  logic sleep_i,
   input  logic clr_i,
   output logic flag_o,
   output logic wake_o
);
   logic prev_q;
   logic flag_q;
   logic rise;
   logic fall;
   logic hit;

   assign rise = pin_sync_i & ~prev_q;
   assign fall = ~pin_sync_i & prev_q;
   assign hit  = ~sleep_i & (pol_i ? rise : fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         flag_q <= FLAG_INIT;
      end else begin
         prev_q <= pin_sync_i;
         flag_q <= (flag_q & ~clr_i) | hit;
      end
   end

   // level match on the raw pin, no clock involved
   assign wake_o = en_i & sleep_i & ~(pin_raw_i ^ pol_i);
   assign flag_o = flag_q;

   assert_flag_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_i) |=> flag_q);
   assert_edge_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && clr_i) |=> flag_q);
   assert_frozen_in_sleep_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_i && !flag_q) |=> !flag_q);
endmodule

// File: rtl/piw_regs.sv
module piw_regs
   import piw_pkg::*;
#(
   parameter int unsigned NUM_PINS = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [NUM_PINS-1:0]   wr_data,
   input  logic [REG_ADDR_W-1:0] rd_addr,
   input  logic [NUM_PINS-1:0]   flags_i,
   output logic [NUM_PINS-1:0]   pol_o,
   output logic [NUM_PINS-1:0]   en_o,
   output logic [NUM_PINS-1:0]   clr_o,
   output logic [NUM_PINS-1:0]   rd_data
);
   logic [NUM_PINS-1:0] pol_q;
   logic [NUM_PINS-1:0] en_q;
   reg_sel_e            wsel;
   reg_sel_e            rsel;

   assign wsel = reg_sel_e'(wr_addr);
   assign rsel = reg_sel_e'(rd_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q <= '0;
         en_q  <= '0;
      end else if (wr_en) begin
         if (wsel == REG_POL) pol_q <= wr_data;
         if (wsel == REG_EN)  en_q  <= wr_data;
      end
   end

   assign clr_o = (wr_en && wsel == REG_FLAG) ? wr_data : '0;

   always_comb begin
      unique case (rsel)
         REG_POL:  rd_data = pol_q;
         REG_EN:   rd_data = en_q;
         REG_FLAG: rd_data = flags_i;
         default:  rd_data = '0;
      endcase
   end

   assign pol_o = pol_q;
   assign en_o  = en_q;

   assert_pol_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wsel == REG_POL) |=> (pol_q == $past(wr_data)));
   assert_en_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wsel == REG_EN) |=> (en_q == $past(wr_data)));
endmodule

// File: rtl/piw_sleep_ctl.sv
module piw_sleep_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic enter_i,
   input  logic wake_any_i,
   output logic sleep_o
);
   logic sleep_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sleep_q <= 1'b0;
      else if (enter_i)    sleep_q <= 1'b1;
      else if (wake_any_i) sleep_q <= 1'b0;
   end

   assign sleep_o = sleep_q;

   assert_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      enter_i |=> sleep_q);
   assert_exit_on_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_q && wake_any_i && !enter_i) |=> !sleep_q);
endmodule

// File: rtl/pin_irq_wake.sv
module pin_irq_wake
   import piw_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          FLAG_INIT   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PINS-1:0]   pin_i,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [NUM_PINS-1:0]   wr_data,
   input  logic [REG_ADDR_W-1:0] rd_addr,
   output logic [NUM_PINS-1:0]   rd_data,
   input  logic                  sleep_enter,
   output logic                  irq_o,
   output logic                  wake_o
);
   if (NUM_PINS < 1 || NUM_PINS > 32) begin : g_bad_pins
      $error("pin_irq_wake: NUM_PINS must be in 1..32");
   end

   logic [NUM_PINS-1:0] pin_s;
   logic [NUM_PINS-1:0] pol;
   logic [NUM_PINS-1:0] en;
   logic [NUM_PINS-1:0] clr;
   logic [NUM_PINS-1:0] flags;
   logic [NUM_PINS-1:0] wake_vec;
   logic                sleep;

   piw_regs #(.NUM_PINS(NUM_PINS)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .flags_i (flags),
      .pol_o   (pol),
      .en_o    (en),
      .clr_o   (clr),
      .rd_data (rd_data)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      piw_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (pin_i[p]),
         .q_o   (pin_s[p])
      );
      piw_pin_cell #(.FLAG_INIT(FLAG_INIT)) u_cell (
         .clk        (clk),
         .rst_n      (rst_n),
         .pin_raw_i  (pin_i[p]),
         .pin_sync_i (pin_s[p]),
         .pol_i      (pol[p]),
         .en_i       (en[p]),
         .sleep_i    (sleep),
         .clr_i      (clr[p]),
         .flag_o     (flags[p]),
         .wake_o     (wake_vec[p])
      );
   end

   piw_sleep_ctl u_sleep (
      .clk        (clk),
      .rst_n      (rst_n),
      .enter_i    (sleep_enter),
      .wake_any_i (wake_o),
      .sleep_o    (sleep)
   );

   assign wake_o = |wake_vec;
   assign irq_o  = |(flags & en);

   assert_wake_only_asleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> sleep);
endmodule

// File: tb/pin_irq_wake_tb.sv
module pin_irq_wake_tb;
   localparam int  N          = 4;
   localparam int  STAGES     = 2;
   localparam time CLK_PERIOD = 10ns;
   localparam time QTR        = CLK_PERIOD / 4;

   logic          clk_free = 1'b0;
   logic          run_en   = 1'b1;
   logic          dut_clk;
   logic          rst_n    = 1'b0;
   logic [N-1:0]  pin      = 4'b1010;
   logic          wr_en    = 1'b0;
   logic [1:0]    wr_addr  = 2'd0;
   logic [N-1:0]  wr_data  = '0;
   logic [1:0]    rd_addr  = 2'd2;
   logic [N-1:0]  rd_data;
   logic          sleep_enter = 1'b0;
   logic          irq, wake;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 0;

   always #(CLK_PERIOD/2) clk_free = ~clk_free;
   assign dut_clk = clk_free & run_en;

   pin_irq_wake #(.NUM_PINS(N), .SYNC_STAGES(STAGES)) u_dut (
      .clk(dut_clk), .rst_n(rst_n), .pin_i(pin),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .sleep_enter(sleep_enter), .irq_o(irq), .wake_o(wake)
   );

   // ---------------- reference model ----------------
   logic [N-1:0] m_pol, m_en, m_flag;
   bit           m_sleep;
   bit           flags_known;
   logic [N-1:0] hist[$];

   function automatic bit m_wake();
      logic [N-1:0] lvl;
      lvl = m_en & ~(pin ^ m_pol);
      return m_sleep && (lvl != '0);
   endfunction

   always @(posedge dut_clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pol = '0; m_en = '0; m_flag = '0; m_sleep = 0; flags_known = 0;
         hist = {};
         for (int i = 0; i <= STAGES; i++) hist.push_back('0);
      end else begin
         logic [N-1:0] now_v, old_v, caught, clr_v;
         bit           wk;
         now_v  = hist[STAGES-1];
         old_v  = hist[STAGES];
         caught = m_sleep ? '0 : ((m_pol & now_v & ~old_v) | (~m_pol & ~now_v & old_v));
         clr_v  = (wr_en && wr_addr == 2'd2) ? wr_data : '0;
         wk     = m_wake();
         m_flag = (m_flag & ~clr_v) | caught;
         if (clr_v == '1) flags_known = 1;
         if (wr_en && wr_addr == 2'd0) m_pol = wr_data;
         if (wr_en && wr_addr == 2'd1) m_en  = wr_data;
         if (sleep_enter) m_sleep = 1;
         else if (wk)     m_sleep = 0;
         hist.push_front(pin);
         void'(hist.pop_back());
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
      end
   endtask

   // per-cycle comparison, mid-cycle
   always @(negedge clk_free) begin
      if (!done) begin
         logic [N-1:0] exp_rd;
         bit           cmp_rd;
         cmp_rd = 1;
         unique case (rd_addr)
            2'd0: exp_rd = m_pol;
            2'd1: exp_rd = m_en;
            2'd2: begin exp_rd = m_flag; cmp_rd = flags_known; end
            default: exp_rd = '0;
         endcase
         if (cmp_rd) check(rd_data === exp_rd, "R1 rd_data", rd_data, exp_rd);
         if (flags_known || m_en == '0)
            check(irq === |(m_flag & m_en), "R6 irq", irq, |(m_flag & m_en));
         check(wake === m_wake(), "R7 wake", wake, m_wake());
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step(input int n = 1);
      repeat (n) @(posedge clk_free);
      #(QTR);
   endtask

   task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
      step();
      wr_en = 1; wr_addr = a; wr_data = d;
      step();
      wr_en = 0;
   endtask

   task automatic gate(input bit on);
      @(posedge clk_free);
      #(3*QTR);
      run_en = on;
   endtask

   task automatic pulse_sleep();
      step();
      sleep_enter = 1;
      step();
      sleep_enter = 0;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   // ---------------- scenarios ----------------
   initial begin
      step(3);
      rst_n = 1;
      @(negedge clk_free);
      rd_addr = 2'd1;
      #1 check(rd_data === '0, "R1 enable reset", rd_data, 0);
      check(irq === 1'b0 && wake === 1'b0, "R6 R7 outputs after reset", {irq, wake}, 0);
      rd_addr = 2'd2;
      step(4);
      wr(2'd2, '1);
      @(negedge clk_free);
      check(rd_data === '0, "R4 clear all", rd_data, 0);

      // R1 register write/read
      wr(2'd0, 4'b0101);
      wr(2'd1, 4'b1111);
      rd_addr = 2'd0; #1 check(rd_data === 4'b0101, "R1 polarity readback", rd_data, 4'b0101);
      rd_addr = 2'd3; #1 check(rd_data === '0, "R1 unused address", rd_data, 0);
      rd_addr = 2'd2;
      step(4);
      wr(2'd2, '1);

      // R2 rising latency
      step(); pin[0] = 1;
      step(2); @(negedge clk_free);
      check(rd_data[0] === 1'b0, "R2 not yet after second edge", rd_data, 0);
      step(); @(negedge clk_free);
      check(rd_data[0] === 1'b1, "R2 set after third edge", rd_data, 1);
      check(irq === 1'b1, "R6 irq from enabled flag", irq, 1);

      // R4 partial clear leaves others
      step(); pin[1] = 0;
      step(4);
      wr(2'd2, 4'b0001);
      @(negedge clk_free);
      check(rd_data === 4'b0010, "R3 falling flag kept, R4 bit0 cleared", rd_data, 4'b0010);
      wr(2'd2, '1);

      // R6 disabled pin
      wr(2'd1, 4'b1011);
      step(); pin[2] = 1;
      step(4); @(negedge clk_free);
      check(rd_data === 4'b0100 && irq === 1'b0, "R6 disabled flag no irq", {irq, rd_data}, 4'b0100);
      step(); pin[2] = 0;
      wr(2'd1, 4'b1111);
      wr(2'd2, '1);

      // R5 edge coincides with clear
      step(); pin[0] = 0;
      step(4);
      wr(2'd2, '1);
      step(); pin[0] = 1;
      step(); step();
      wr_en = 1; wr_addr = 2'd2; wr_data = 4'b0001;
      step();
      wr_en = 0;
      @(negedge clk_free);
      check(rd_data[0] === 1'b1, "R5 edge wins over clear", rd_data, 1);
      wr(2'd2, '1);

      // R12 pulse of 1.5 periods
      step(); pin[2] = 1;
      step(); #(CLK_PERIOD/2); pin[2] = 0;
      step(4); @(negedge clk_free);
      check(rd_data[2] === 1'b1, "R12 wide pulse captured", rd_data, 4'b0100);
      wr(2'd2, '1);

      // Sleep S1: rising wake, disabled pin, no flags in sleep
      step(); pin[0] = 0; pin[2] = 0;
      wr(2'd1, 4'b0001);
      step(4);
      wr(2'd2, '1);
      pulse_sleep();
      step(2); @(negedge clk_free);
      check(wake === 1'b0, "R7 no wake at inactive level", wake, 0);
      step(); pin[2] = 1;
      step(5); @(negedge clk_free);
      check(rd_data === '0, "R11 no flag while asleep", rd_data, 0);
      check(wake === 1'b0, "R7 disabled pin ignored", wake, 0);
      gate(0);
      #(CLK_PERIOD); pin[0] = 1;
      #1 check(wake === 1'b1, "R7 rising high wakes without clock", wake, 1);
      gate(1);
      @(negedge clk_free);
      check(wake === 1'b0, "R10 wake drops after exit", wake, 0);
      step(4);
      wr(2'd2, '1);

      // Sleep S2: falling pin high at entry
      step(); pin[1] = 1;
      wr(2'd1, 4'b0010);
      step(4);
      wr(2'd2, '1);
      pulse_sleep();
      gate(0);
      #(CLK_PERIOD);
      check(wake === 1'b0, "R9 high falling pin keeps sleep", wake, 0);
      pin[1] = 0;
      #1 check(wake === 1'b1, "R9 wake on going low", wake, 1);
      gate(1);
      @(negedge clk_free);
      check(wake === 1'b0, "R10 exit after wake", wake, 0);
      step(); pin[1] = 1;
      step(4);
      wr(2'd2, '1);

      // Sleep S3: already active at entry, entry priority
      step(); pin[3] = 0;
      wr(2'd1, 4'b1000);
      step(4);
      step(); sleep_enter = 1;
      step(); @(negedge clk_free);
      check(wake === 1'b1, "R8 immediate wake at entry", wake, 1);
      step(); sleep_enter = 0;
      @(negedge clk_free);
      check(wake === 1'b1, "R10 entry beats exit", wake, 1);
      step(); @(negedge clk_free);
      check(wake === 1'b0, "R10 leaves sleep", wake, 0);

      step(4);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule